// File: doc/BRIEF.md
# Counter-Addressed Nibble SRAM Station

This block is a sixteen-word by four-bit static memory with its own address counter. An up/down counter, with a synchronous clear, supplies the word address, so the memory steps through its locations without any address bus. The current address is shown on a four-bit output that drives indicator lamps.

A word is stored in three steps. The counter is moved to the wanted location. A nibble is placed on the data input. Write enable is then pulsed low while chip select is low. The word is committed when write enable returns high. Reads put the addressed word on the data output, which feeds a BCD display path. The bidirectional data pin is split into three signals: data-in, data-out and a drive-enable. The drive-enable stands in for the pad's tri-state control. All controls are active low and are sampled on the rising clock edge.

Top module: `sram_nibble_station`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `addr_out` is 0.
- R2: At a clock edge with `addr_up`=1, `addr_dn`=0 and `addr_clr`=0, the address rises by one and wraps from 15 to 0.
- R3: At an edge with `addr_dn`=1, `addr_up`=0 and `addr_clr`=0, the address falls by one and wraps from 0 to 15. With both `addr_up` and `addr_dn` high, the address holds.
- R4: At an edge with `addr_clr`=1, the address becomes 0 whatever the count inputs are.
- R5: A write happens at the first clock edge where `we_n` is sampled 1 after being sampled 0 at the edge before, with `cs_n`=0 at that edge. The stored value is `din` as sampled at that edge. The target is the address held before that edge, even if the counter moves on the same edge.
- R6: If `cs_n` is 1 at the edge that ends a `we_n` low pulse, nothing is stored and the addressed word keeps its old value.
- R7: `dout_en` is 1 exactly when `cs_n`=0, `oe_n`=0 and `we_n`=1. When `dout_en` is 1, `dout` shows the word at `addr_out`. When it is 0, `dout` is 0.
- R8: A stored word is unchanged by any number of reads, address moves and clears until it is written again.
- R9: All 16 addresses 0..15 select distinct words. No location aliases another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the address counter |
| addr_up | input | 1 | Count the address up |
| addr_dn | input | 1 | Count the address down |
| addr_clr | input | 1 | Synchronous clear of the address |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable; the write commits when it rises |
| oe_n | input | 1 | Active-low output enable |
| din | input | 4 | Nibble to be written |
| dout | output | 4 | Read data, 0 when not driven |
| dout_en | output | 1 | Drive-enable for the data pad |
| addr_out | output | 4 | Current address for indicator lamps |

## Verification
The bench pushes the counter across both wrap points and asserts clear together with a count. A design that wrapped wrongly, or let a count override clear, would show the wrong lamp value.

It writes a word on the same edge that the counter steps. A design that used the post-step address would put that word into the neighbouring location.

It ends a write pulse while deselected. A design that ignored chip select would overwrite the word.

It fills all sixteen words with distinct values and walks the output-enable combinations. A design that aliased addresses, or drove the pad while write enable was low, would return the wrong nibble or raise `dout_en`.

// File: rtl/sram_nibble_station.sv
module sram_nibble_station #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_up,
  input  logic              addr_dn,
  input  logic              addr_clr,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              we_q;
  logic              wr_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      addr_q <= '0;
    else if (addr_clr)
      addr_q <= '0;
    else if (addr_up && !addr_dn)
      addr_q <= addr_q + 1'b1;
    else if (addr_dn && !addr_up)
      addr_q <= addr_q - 1'b1;

  always_ff @(posedge clk)
    we_q <= we_n;

  assign wr_fire = rst_n && !cs_n && we_n && !we_q;

  always_ff @(posedge clk)
    if (wr_fire)
      mem[addr_q] <= din;

  assign dout_en  = !cs_n && !oe_n && we_n;
  assign dout     = dout_en ? mem[addr_q] : '0;
  assign addr_out = addr_q;
endmodule

// File: rtl/sram_nibble_station_chk.sv
module sram_nibble_station_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_up,
  input logic              addr_dn,
  input logic              addr_clr,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic [ADDR_W-1:0] addr_out
);
  always_comb
    if (!rst_n) assert_reset_addr_R1: assert (addr_out == '0);

  assert_addr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_clr |=> addr_out == '0);

  assert_addr_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_up && !addr_dn && !addr_clr) |=> addr_out == ADDR_W'($past(addr_out) + 1'b1));

  assert_addr_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_dn && !addr_up && !addr_clr) |=> addr_out == ADDR_W'($past(addr_out) - 1'b1));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_dn && addr_up && !addr_clr) |=> $stable(addr_out));

  assert_quiet_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);

  assert_drive_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!cs_n && !oe_n && we_n));

  assert_write_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !cs_n && !addr_up && !addr_dn && !addr_clr)
      |=> (cs_n || oe_n || !we_n || !$stable(addr_out) || dout == $past(din)));
endmodule

bind sram_nibble_station sram_nibble_station_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_sram_nibble_station.sv
module test_sram_nibble_station;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       addr_up = 0, addr_dn = 0, addr_clr = 0;
  logic       cs_n = 1, we_n = 1, oe_n = 1;
  logic [3:0] din = 0;
  logic [3:0] dout;
  logic       dout_en;
  logic [3:0] addr_out;

  int n_chk = 0, n_fail = 0;
  logic [3:0] exp_addr = 0;

  always #10 clk = ~clk;

  sram_nibble_station i_sram_nibble_station (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input logic up, input logic dn, input logic clr);
    addr_up = up; addr_dn = dn; addr_clr = clr;
    @(negedge clk);
    addr_up = 0; addr_dn = 0; addr_clr = 0;
  endtask

  task automatic goto_addr(input int a);
    step(0, 0, 1);
    for (int i = 0; i < a; i++) step(1, 0, 0);
    exp_addr = 4'(a);
  endtask

  task automatic write_word(input logic [3:0] v, input logic sel_at_end, input logic up_at_end);
    oe_n = 1; cs_n = 0; din = v; we_n = 0;
    @(negedge clk);
    we_n = 1; cs_n = sel_at_end ? 1'b0 : 1'b1; addr_up = up_at_end;
    @(negedge clk);
    addr_up = 0; cs_n = 0;
  endtask

  task automatic read_check(input logic [3:0] v, input string tag);
    cs_n = 0; oe_n = 0; we_n = 1;
    #1;
    chk(dout_en === 1'b1, tag, dout_en, 1);
    chk(dout === v, tag, dout, v);
    oe_n = 1;
  endtask

  task automatic t_reset;
    chk(addr_out === 4'd0, "R1 addr during reset", addr_out, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(addr_out === 4'd0, "R1 addr after reset", addr_out, 0);
    chk(dout_en === 1'b0 && dout === 4'd0, "R7 idle not driven", dout, 0);
  endtask

  task automatic t_count_up;
    for (int i = 0; i < 17; i++) begin
      step(1, 0, 0);
      exp_addr = exp_addr + 1'b1;
      chk(addr_out === exp_addr, "R2 count up", addr_out, exp_addr);
    end
  endtask

  task automatic t_count_down;
    goto_addr(0);
    step(0, 1, 0);
    chk(addr_out === 4'd15, "R3 wrap down", addr_out, 15);
    step(0, 1, 0);
    chk(addr_out === 4'd14, "R3 count down", addr_out, 14);
    step(1, 1, 0);
    step(1, 1, 0);
    chk(addr_out === 4'd14, "R3 both hold", addr_out, 14);
  endtask

  task automatic t_clear;
    step(1, 0, 1);
    chk(addr_out === 4'd0, "R4 clear beats up", addr_out, 0);
    step(1, 0, 0); step(1, 0, 0);
    step(0, 1, 1);
    chk(addr_out === 4'd0, "R4 clear beats down", addr_out, 0);
  endtask

  task automatic t_fill_all;
    goto_addr(0);
    for (int a = 0; a < 16; a++) begin
      write_word(4'(a * 7 + 3), 1'b1, 1'b0);
      step(1, 0, 0);
    end
    chk(addr_out === 4'd0, "R2 wrap after fill", addr_out, 0);
    for (int a = 0; a < 16; a++) begin
      read_check(4'(a * 7 + 3), "R9 distinct word");
      step(1, 0, 0);
    end
  endtask

  task automatic t_write_on_step;
    goto_addr(5);
    write_word(4'hC, 1'b1, 1'b1);
    chk(addr_out === 4'd6, "R5 counter moved on write edge", addr_out, 6);
    read_check(4'(6 * 7 + 3), "R5 next word untouched");
    step(0, 1, 0);
    read_check(4'hC, "R5 word at pre-edge address");
  endtask

  task automatic t_deselected;
    goto_addr(3);
    write_word(4'hA, 1'b0, 1'b0);
    read_check(4'(3 * 7 + 3), "R6 deselected write ignored");
  endtask

  task automatic t_drive;
    goto_addr(2);
    cs_n = 1; oe_n = 0; we_n = 1; #1;
    chk(dout_en === 0 && dout === 0, "R7 cs high", dout_en, 0);
    cs_n = 0; oe_n = 1; #1;
    chk(dout_en === 0 && dout === 0, "R7 oe high", dout_en, 0);
    oe_n = 0; we_n = 0; #1;
    chk(dout_en === 0 && dout === 0, "R7 we low", dout_en, 0);
    cs_n = 1; we_n = 1;
    @(negedge clk);
    read_check(4'(2 * 7 + 3), "R7 all enabled");
  endtask

  task automatic t_persist;
    goto_addr(9);
    for (int i = 0; i < 5; i++) read_check(4'(9 * 7 + 3), "R8 repeated read");
    for (int i = 0; i < 20; i++) step(i % 3 == 0, i % 3 == 1, 0);
    step(0, 0, 1);
    goto_addr(9);
    read_check(4'(9 * 7 + 3), "R8 after moves");
    goto_addr(5);
    read_check(4'hC, "R8 earlier write kept");
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count_up();
    t_count_down();
    t_clear();
    t_fill_all();
    t_write_on_step();
    t_deselected();
    t_drive();
    t_persist();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule